// File: doc/BRIEF.md
# Dual-Timer Capture/Compare Unit

The unit holds two 16-bit up-counting timers and sixteen 16-bit channel registers. Each channel is assigned to one of the two timers. A channel either records the assigned timer's count when its input has an edge, or compares that count against its register and acts on the output bit that belongs to it. A flat word-wide register bus sets up the timers, the channel modes, the timer assignment and the output-switching options. The same bus reads back every register, and reads the committed output word. Every channel event raises that channel's bit of the interrupt-request vector for one cycle.

Each timer advances on a strobe from a shared free-running prescaler, at 1/2^s of the module clock. The first timer can instead count synchronized rising edges of an external input. When a timer steps from all-ones, it takes its reload value instead of wrapping to zero. Compare outputs can be committed all together, or in a rotating eight-step schedule that spreads the switching over eight clock cycles. In a paired mode, a low channel sets a shared output and its partner eight positions up clears that output.

Top module: `capcom_unit`

## Requirements
- R1: Control word at address 0x17 holds these fields: bits [2:0] prescale select of timer 0, bits [5:3] prescale select of timer 1, bit 6 run for timer 0, bit 7 run for timer 1, bit 8 staggered commit, bit 9 paired mode. With run set and select s (0..6), a timer advances by one every 2^s clock cycles. Select 7 on timer 1 means one step every 128 cycles. A timer whose run bit is clear holds its count.
- R2: A timer that steps while at 0xFFFF loads its reload value. Timer 0 reloads from address 0x12 and timer 1 from 0x13.
- R3: With select 7 and run set, timer 0 advances once per rising edge of ext_i. The edge is taken after a two-flop synchronizer, and the prescaler has no effect in this mode.
- R4: Counts are written and read at addresses 0x10 (timer 0) and 0x11 (timer 1). A bus write to a count takes priority over a step in the same cycle. Channel n's register is at address n (0x00-0x0F). The committed output word reads at 0x18. A read returns data in the same cycle as the address.
- R5: Channel n's mode is the 2-bit field at bits [2n+1:2n] of the 32-bit mode value. Address 0x14 holds channels 0-7 and address 0x15 holds channels 8-15. The codes are 00 off, 01 capture on rising edge, 10 capture on falling edge, 11 compare. Bit n at address 0x16 assigns channel n to timer 1 when set and to timer 0 when clear.
- R6: In mode 01, a rising edge on cap_i[n] copies the assigned timer's count into channel n's register and pulses irq_o[n] for one cycle. A capture takes priority over a bus write to the same register.
- R7: In mode 10 only falling edges capture. A rising edge leaves the register unchanged and raises no request.
- R8: In mode 11, when the assigned timer steps to the channel's value, irq_o[n] is high in the cycle in which the timer reads that value. Outside paired mode, output bit n toggles. With staggered commit off, the toggle appears in that same cycle.
- R9: A channel in mode 00 never raises its request and its register ignores input edges.
- R10: In paired mode, a compare match on channel n (n<8) sets output n, and a match on channel n+8 clears output n. When both match in the same cycle, the clear wins. Output bits 8-15 hold their value in this mode.
- R11: With staggered commit on, a free-running step index k (0..7) advances each cycle. In each cycle only the pending values of output bits 2k and 2k+1 are committed. Two outputs whose channels match together therefore change k positions apart, modulo 8.
- R12: Interrupt requests never wait for the staggered schedule. They follow R8 timing in both commit modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Module clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 5 | Register address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for addr_i |
| cap_i | input | 16 | Per-channel capture inputs, asynchronous |
| ext_i | input | 1 | External count input for timer 0 |
| cmp_o | output | 16 | Committed compare outputs |
| irq_o | output | 16 | Per-channel interrupt requests, one-cycle pulses |

## Verification
The assertions assume that the capture inputs and the external count input stay at one level for at least two clock cycles between changes, so every edge passes the synchronizer. They also assume that bus writes come one at a time and last one cycle. The stimulus changes cap_i and ext_i only at falling clock edges, holds them for several cycles, and issues each write as a single-cycle strobe. Compare values are drawn at random from a window that stays below the timer's wrap point, so the random compare runs never cross a reload.

// File: rtl/capcom_pkg.sv
package capcom_pkg;
  typedef enum logic [1:0] {
    CH_OFF      = 2'b00,
    CH_CAP_RISE = 2'b01,
    CH_CAP_FALL = 2'b10,
    CH_CMP      = 2'b11
  } ch_mode_e;
endpackage

// File: rtl/capcom_timer.sv
module capcom_timer #(
  parameter int unsigned TW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          cnt_we_i,
  input  logic          rel_we_i,
  input  logic [TW-1:0] wdata_i,
  output logic [TW-1:0] cnt_o,
  output logic [TW-1:0] rel_o,
  output logic [TW-1:0] nxt_o,
  output logic          adv_o
);
  logic [TW-1:0] cnt_q, rel_q;

  assign adv_o = tick_i & ~cnt_we_i;
  assign nxt_o = (cnt_q == '1) ? rel_q : cnt_q + 1'b1;
  assign cnt_o = cnt_q;
  assign rel_o = rel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      rel_q <= '0;
    end else begin
      if (cnt_we_i)    cnt_q <= wdata_i;
      else if (tick_i) cnt_q <= nxt_o;
      if (rel_we_i)    rel_q <= wdata_i;
    end
  end

  // R2
  wrap_reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !cnt_we_i && cnt_q == '1) |=> cnt_q == $past(rel_q));
  // R1
  hold_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !cnt_we_i) |=> $stable(cnt_q));
  // R4
  write_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_we_i |=> cnt_q == $past(wdata_i));
endmodule

// File: rtl/capcom_channel.sv
module capcom_channel
  import capcom_pkg::*;
#(
  parameter int unsigned TW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sig_i,
  input  ch_mode_e      mode_i,
  input  logic          tsel_i,
  input  logic [TW-1:0] cnt_a_i,
  input  logic [TW-1:0] cnt_b_i,
  input  logic [TW-1:0] nxt_a_i,
  input  logic [TW-1:0] nxt_b_i,
  input  logic          adv_a_i,
  input  logic          adv_b_i,
  input  logic          we_i,
  input  logic [TW-1:0] wdata_i,
  output logic [TW-1:0] val_o,
  output logic          match_o,
  output logic          irq_o
);
  logic s1_q, s2_q, prev_q, irq_q;
  logic [TW-1:0] val_q, cnt_sel, nxt_sel;
  logic adv_sel, rise, fall, cap_ev;

  assign cnt_sel = tsel_i ? cnt_b_i : cnt_a_i;
  assign nxt_sel = tsel_i ? nxt_b_i : nxt_a_i;
  assign adv_sel = tsel_i ? adv_b_i : adv_a_i;
  assign rise    = s2_q & ~prev_q;
  assign fall    = ~s2_q & prev_q;
  assign cap_ev  = (mode_i == CH_CAP_RISE && rise) || (mode_i == CH_CAP_FALL && fall);
  assign match_o = (mode_i == CH_CMP) && adv_sel && (nxt_sel == val_q);
  assign val_o   = val_q;
  assign irq_o   = irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q   <= 1'b0;
      s2_q   <= 1'b0;
      prev_q <= 1'b0;
      irq_q  <= 1'b0;
      val_q  <= '0;
    end else begin
      s1_q   <= sig_i;
      s2_q   <= s1_q;
      prev_q <= s2_q;
      irq_q  <= cap_ev | match_o;
      if (cap_ev)    val_q <= cnt_sel;
      else if (we_i) val_q <= wdata_i;
    end
  end

  // R9
  off_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == CH_OFF && !we_i) |=> (!irq_o && $stable(val_q)));
  // R6
  cap_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == CH_CAP_RISE && s2_q && !prev_q) |=> (irq_o && val_q == $past(cnt_sel)));
  // R7
  cap_fall_ignore_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == CH_CAP_FALL && s2_q && !prev_q && !we_i) |=> (!irq_o && $stable(val_q)));
endmodule

// File: rtl/capcom_outs.sv
module capcom_outs #(
  parameter int unsigned NCH = 16
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [NCH-1:0] match_i,
  input  logic           dbl_i,
  input  logic           stag_i,
  output logic [NCH-1:0] out_o
);
  localparam int unsigned HALF = NCH / 2;
  localparam int unsigned SW   = $clog2(HALF);

  logic [NCH-1:0] pend_q, pend_d, out_q, pair_m;
  logic [SW-1:0]  step_q;

  assign pair_m = {{(NCH-2){1'b0}}, 2'b11} << {step_q, 1'b0};
  assign out_o  = out_q;

  for (genvar i = 0; i < NCH; i++) begin : g_bit
    if (i < HALF) begin : g_lo
      // clear from the partner overrides set
      assign pend_d[i] = dbl_i ? (match_i[i+HALF] ? 1'b0 : (match_i[i] | pend_q[i]))
                               : (pend_q[i] ^ match_i[i]);
      // R10
      clear_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (dbl_i && match_i[i+HALF]) |=> !pend_q[i]);
    end else begin : g_hi
      assign pend_d[i] = dbl_i ? pend_q[i] : (pend_q[i] ^ match_i[i]);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  out_q[i] <= 1'b0;
      else if (!stag_i || step_q == SW'(i / 2))     out_q[i] <= pend_d[i];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      step_q <= '0;
    end else begin
      pend_q <= pend_d;
      step_q <= step_q + 1'b1;
    end
  end

  // R11
  stag_pair_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stag_i |=> ((out_q ^ $past(out_q)) & ~$past(pair_m)) == '0);
  // R8
  direct_commit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stag_i |=> out_q == pend_q);
endmodule

// File: rtl/capcom_unit.sv
module capcom_unit
  import capcom_pkg::*;
#(
  parameter int unsigned TW  = 16,
  parameter int unsigned NCH = 16,
  parameter int unsigned AW  = 5,
  parameter int unsigned PW  = 7
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           we_i,
  input  logic [AW-1:0]  addr_i,
  input  logic [TW-1:0]  wdata_i,
  output logic [TW-1:0]  rdata_o,
  input  logic [NCH-1:0] cap_i,
  input  logic           ext_i,
  output logic [NCH-1:0] cmp_o,
  output logic [NCH-1:0] irq_o
);
  localparam int unsigned MW = (2 * NCH) / TW;
  localparam int unsigned CW = $clog2(NCH);
  localparam logic [AW-1:0] A_CNT   = AW'(NCH);
  localparam logic [AW-1:0] A_REL   = AW'(NCH + 2);
  localparam logic [AW-1:0] A_MODE  = AW'(NCH + 4);
  localparam logic [AW-1:0] A_ALLOC = AW'(NCH + 4 + MW);
  localparam logic [AW-1:0] A_CTRL  = AW'(NCH + 5 + MW);
  localparam logic [AW-1:0] A_OUT   = AW'(NCH + 6 + MW);

  logic [TW-1:0]    cnt [2];
  logic [TW-1:0]    rel [2];
  logic [TW-1:0]    nxt [2];
  logic             adv [2];
  logic             tick [2];
  logic [2:0]       sel_q [2];
  logic             run_q [2];
  logic             stag_q, dbl_q;
  logic [2*NCH-1:0] mode_q;
  logic [NCH-1:0]   alloc_q, match;
  logic [TW-1:0]    val [NCH];
  logic [PW-1:0]    pre_q;
  logic             e1_q, e2_q, e3_q, ext_rise;

  assign ext_rise = e2_q & ~e3_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q   <= '{default: '0};
      run_q   <= '{default: 1'b0};
      stag_q  <= 1'b0;
      dbl_q   <= 1'b0;
      mode_q  <= '0;
      alloc_q <= '0;
      pre_q   <= '0;
      e1_q    <= 1'b0;
      e2_q    <= 1'b0;
      e3_q    <= 1'b0;
    end else begin
      pre_q <= pre_q + 1'b1;
      e1_q  <= ext_i;
      e2_q  <= e1_q;
      e3_q  <= e2_q;
      if (we_i && addr_i == A_CTRL) begin
        sel_q[0] <= wdata_i[2:0];
        sel_q[1] <= wdata_i[5:3];
        run_q[0] <= wdata_i[6];
        run_q[1] <= wdata_i[7];
        stag_q   <= wdata_i[8];
        dbl_q    <= wdata_i[9];
      end
      if (we_i && addr_i == A_ALLOC) alloc_q <= wdata_i[NCH-1:0];
      for (int w = 0; w < MW; w++)
        if (we_i && addr_i == A_MODE + AW'(w)) mode_q[w*TW +: TW] <= wdata_i;
    end
  end

  for (genvar t = 0; t < 2; t++) begin : g_tmr
    logic [PW-1:0] mask;
    logic          ext_mode;
    assign mask     = ~({PW{1'b1}} << sel_q[t]);
    assign ext_mode = (t == 0) && (sel_q[t] == 3'd7);
    assign tick[t]  = run_q[t] && (ext_mode ? ext_rise : ((pre_q & mask) == mask));

    capcom_timer #(.TW(TW)) u_tmr (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .tick_i   (tick[t]),
      .cnt_we_i (we_i && addr_i == A_CNT + AW'(t)),
      .rel_we_i (we_i && addr_i == A_REL + AW'(t)),
      .wdata_i  (wdata_i),
      .cnt_o    (cnt[t]),
      .rel_o    (rel[t]),
      .nxt_o    (nxt[t]),
      .adv_o    (adv[t])
    );
  end

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    capcom_channel #(.TW(TW)) u_ch (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .sig_i   (cap_i[n]),
      .mode_i  (ch_mode_e'(mode_q[2*n +: 2])),
      .tsel_i  (alloc_q[n]),
      .cnt_a_i (cnt[0]),
      .cnt_b_i (cnt[1]),
      .nxt_a_i (nxt[0]),
      .nxt_b_i (nxt[1]),
      .adv_a_i (adv[0]),
      .adv_b_i (adv[1]),
      .we_i    (we_i && addr_i == AW'(n)),
      .wdata_i (wdata_i),
      .val_o   (val[n]),
      .match_o (match[n]),
      .irq_o   (irq_o[n])
    );
  end

  capcom_outs #(.NCH(NCH)) u_out (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .match_i (match),
    .dbl_i   (dbl_q),
    .stag_i  (stag_q),
    .out_o   (cmp_o)
  );

  always_comb begin
    rdata_o = '0;
    if (addr_i < AW'(NCH)) rdata_o = val[addr_i[CW-1:0]];
    for (int t = 0; t < 2; t++) begin
      if (addr_i == A_CNT + AW'(t)) rdata_o = cnt[t];
      if (addr_i == A_REL + AW'(t)) rdata_o = rel[t];
    end
    for (int w = 0; w < MW; w++)
      if (addr_i == A_MODE + AW'(w)) rdata_o = mode_q[w*TW +: TW];
    if (addr_i == A_ALLOC) rdata_o[NCH-1:0] = alloc_q;
    if (addr_i == A_CTRL)
      rdata_o = TW'({dbl_q, stag_q, run_q[1], run_q[0], sel_q[1], sel_q[0]});
    if (addr_i == A_OUT) rdata_o[NCH-1:0] = cmp_o;
  end

  // R3
  ext_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q[0] && sel_q[0] == 3'd7 && !e2_q) |-> !tick[0]);
  // R12
  irq_no_stagger_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match != '0) |=> (irq_o & $past(match)) == $past(match));
endmodule

// File: tb/sim_capcom_unit.sv
module sim_capcom_unit;
  localparam logic [4:0] CNT0 = 5'h10, CNT1 = 5'h11, REL0 = 5'h12,
                         MODE_LO = 5'h14, MODE_HI = 5'h15, ALLOC = 5'h16,
                         CTRL = 5'h17, OUTS = 5'h18;

  logic        clk = 1'b0, rst_ni = 1'b0, we = 1'b0, ext = 1'b0;
  logic [4:0]  addr = '0;
  logic [15:0] wdata = '0, rdata, cap = '0, cmp, irq;
  int          n_chk = 0, n_bad = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  capcom_unit u0 (
    .clk_i(clk), .rst_ni(rst_ni), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .cap_i(cap), .ext_i(ext), .cmp_o(cmp), .irq_o(irq)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(posedge clk); #1 we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [15:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  function automatic logic [15:0] ctrl_w(input int s0, s1, r0, r1, stg, dbl);
    return 16'((s0 & 7) | ((s1 & 7) << 3) | (r0 << 6) | (r1 << 7) | (stg << 8) | (dbl << 9));
  endfunction

  function automatic logic [31:0] mode_one(input int ch, input int m);
    return 32'(m) << (2 * ch);
  endfunction

  // compare run on one channel: irq follows count, output toggles (R8, R12)
  task automatic cmp_run(input int ch, input int ts, input int v);
    logic [15:0] ob, c, oa;
    logic [31:0] md;
    int bad_irq = 0;
    md = mode_one(ch, 3);
    wr(CTRL, 16'h0);
    wr(ALLOC, ts ? 16'(1 << ch) : 16'h0);
    wr(MODE_LO, md[15:0]);
    wr(MODE_HI, md[31:16]);
    wr(5'(ch), 16'(v));
    wr(ts ? CNT1 : CNT0, 16'(v - 5));
    rd(OUTS, ob);
    wr(CTRL, ctrl_w(0, 0, ts == 0, ts == 1, 0, 0));
    addr = ts ? CNT1 : CNT0;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      c = rdata;
      if (irq != ((c == 16'(v)) ? 16'(1 << ch) : 16'h0)) bad_irq++;
    end
    wr(CTRL, 16'h0);
    rd(OUTS, oa);
    chk(bad_irq == 0, "R8 irq at match", bad_irq, 0);
    chk(oa == (ob ^ 16'(1 << ch)), "R8 output toggle", oa, ob ^ 16'(1 << ch));
  endtask

  initial begin
    #(8 * 150000);
    chk(1'b0, "watchdog", 0, 1);
    if (!done) begin
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] d, d2, c, ob, o11;
    int v, r, pulses, ki, k0, k14, bad;
    v = $urandom(32'd2024);
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;

    // reset state
    @(negedge clk);
    chk(irq == 0, "R8 reset irq", irq, 0);
    chk(cmp == 0, "R8 reset outputs", cmp, 0);
    rd(CNT0, d);
    chk(d == 0, "R4 reset count", d, 0);

    // prescale: timer 0 every cycle, timer 1 every 4 cycles, 64 steps window
    wr(CNT0, 0); wr(CNT1, 0);
    wr(CTRL, ctrl_w(0, 2, 1, 1, 0, 0));
    repeat (63) @(posedge clk);
    wr(CTRL, 0);
    rd(CNT0, d);  chk(d == 64, "R1 divide by 1", d, 64);
    rd(CNT1, d);  chk(d == 16, "R1 divide by 4", d, 16);
    repeat (5) @(posedge clk);
    rd(CNT0, d2); chk(d2 == 64, "R1 stopped hold", d2, 64);

    // wrap to reload
    r = int'($urandom_range(16'h7FFF, 16'h0100));
    wr(REL0, 16'(r)); wr(CNT0, 16'hFFFE);
    wr(CTRL, ctrl_w(0, 0, 1, 0, 0, 0));
    repeat (2) @(posedge clk);
    wr(CTRL, 0);
    rd(CNT0, d);  chk(d == 16'(r + 1), "R2 reload after wrap", d, r + 1);

    // write beats step
    wr(CTRL, ctrl_w(0, 0, 1, 0, 0, 0));
    wr(CNT0, 16'h1234);
    rd(CNT0, d);  chk(d == 16'h1234, "R4 write wins", d, 16'h1234);
    wr(CTRL, 0);

    // external count
    wr(CNT0, 0);
    wr(CTRL, ctrl_w(7, 0, 1, 0, 0, 0));
    for (int k = 0; k < 5; k++) begin
      @(negedge clk); ext = 1'b1; repeat (4) @(negedge clk);
      ext = 1'b0; repeat (4) @(negedge clk);
    end
    repeat (4) @(negedge clk);
    wr(CTRL, 0);
    rd(CNT0, d);  chk(d == 5, "R3 external edges", d, 5);

    // capture on rising edge, timer 1
    wr(ALLOC, 16'h0020);
    wr(MODE_LO, 16'(mode_one(5, 1))); wr(MODE_HI, 0);
    wr(CNT1, 16'h0ABC);
    @(negedge clk); cap[5] = 1'b1; pulses = 0;
    repeat (6) begin @(negedge clk); if (irq[5]) pulses++; end
    rd(5'd5, d);
    chk(d == 16'h0ABC, "R6 rising capture value", d, 16'h0ABC);
    chk(pulses == 1, "R6 single request pulse", pulses, 1);
    wr(CNT1, 16'h0DEF);
    @(negedge clk); cap[5] = 1'b0; pulses = 0;
    repeat (6) begin @(negedge clk); if (irq[5]) pulses++; end
    rd(5'd5, d);
    chk(d == 16'h0ABC && pulses == 0, "R5 falling ignored in mode 01", d, 16'h0ABC);

    // falling-edge mode
    wr(MODE_LO, 16'(mode_one(5, 2)));
    @(negedge clk); cap[5] = 1'b1; pulses = 0;
    repeat (6) begin @(negedge clk); if (irq[5]) pulses++; end
    rd(5'd5, d);
    chk(d == 16'h0ABC && pulses == 0, "R7 rising ignored", d, 16'h0ABC);
    wr(CNT1, 16'h0777);
    @(negedge clk); cap[5] = 1'b0; pulses = 0;
    repeat (6) begin @(negedge clk); if (irq[5]) pulses++; end
    rd(5'd5, d);
    chk(d == 16'h0777 && pulses == 1, "R7 falling capture", d, 16'h0777);

    // disabled channel
    wr(MODE_LO, 0);
    wr(CNT1, 16'h0999);
    pulses = 0;
    @(negedge clk); cap[5] = 1'b1;
    repeat (6) begin @(negedge clk); if (irq != 0) pulses++; end
    @(negedge clk); cap[5] = 1'b0;
    repeat (6) begin @(negedge clk); if (irq != 0) pulses++; end
    rd(5'd5, d);
    chk(d == 16'h0777 && pulses == 0, "R9 off channel inert", d, 16'h0777);

    // constrained random compare runs
    for (int k = 0; k < 8; k++) begin
      cmp_run(int'($urandom_range(15, 0)), int'($urandom_range(1, 0)),
              int'($urandom_range(16'hFFF0, 5)));
    end
    cmp_run(0, 0, 5);
    cmp_run(15, 1, 16'hFFF0);

    // paired mode: ch3 sets, ch11 clears output 3
    wr(CTRL, 0); wr(ALLOC, 0);
    wr(MODE_LO, 16'(mode_one(3, 3)));
    wr(MODE_HI, 16'(mode_one(3, 3)));
    wr(5'd3, 20); wr(5'd11, 40); wr(CNT0, 15);
    rd(OUTS, d); o11 = d & 16'h0800;
    wr(CTRL, ctrl_w(0, 0, 1, 0, 0, 1));
    addr = CNT0; bad = 0;
    for (int k = 0; k < 30; k++) begin
      @(negedge clk); c = rdata;
      if (c >= 20 && c < 40 && !cmp[3]) bad++;
      if (c >= 40 && cmp[3]) bad++;
    end
    wr(CTRL, ctrl_w(0, 0, 0, 0, 0, 1));
    chk(bad == 0, "R10 set then clear", bad, 0);
    rd(OUTS, d);
    chk((d & 16'h0800) == o11, "R10 upper bit held", d & 16'h0800, o11);
    wr(5'd3, 70); wr(5'd11, 90); wr(CNT0, 65);
    wr(CTRL, ctrl_w(0, 0, 1, 0, 0, 1));
    repeat (10) @(posedge clk);
    wr(CTRL, ctrl_w(0, 0, 0, 0, 0, 1));
    rd(OUTS, d);
    chk(d[3] == 1'b1, "R10 set by low channel", d[3], 1);
    wr(5'd3, 80); wr(5'd11, 80); wr(CNT0, 78);
    wr(CTRL, ctrl_w(0, 0, 1, 0, 0, 1));
    repeat (6) @(posedge clk);
    wr(CTRL, 0);
    rd(OUTS, d);
    chk(d[3] == 1'b0, "R10 clear wins", d[3], 0);

    // staggered commit: ch0 and ch14 match together
    wr(MODE_LO, 16'(mode_one(0, 3)));
    wr(MODE_HI, 16'(mode_one(6, 3)));
    wr(5'd0, 200); wr(5'd14, 200); wr(CNT0, 195);
    rd(OUTS, ob);
    wr(CTRL, ctrl_w(0, 0, 1, 0, 1, 0));
    addr = CNT0; ki = -1; k0 = -1; k14 = -1; bad = 0;
    for (int k = 0; k < 24; k++) begin
      @(negedge clk); c = rdata;
      if ((irq[0] != (c == 200)) || (irq[14] != (c == 200))) bad++;
      if (irq[0] && ki < 0) ki = k;
      if (cmp[0] != ob[0] && k0 < 0) k0 = k;
      if (cmp[14] != ob[14] && k14 < 0) k14 = k;
    end
    wr(CTRL, 0);
    chk(bad == 0, "R12 requests unstaggered", bad, 0);
    chk(ki >= 0 && k0 >= ki && k0 - ki < 8 && k14 >= ki && k14 - ki < 8,
        "R11 commit within rotation", k0 - ki, 0);
    chk(((k14 - k0 + 8) % 8) == 7, "R11 step distance", (k14 - k0 + 8) % 8, 7);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule